// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a processor core and from its on-chip peripherals, and picks the single request that the core should service next. Peripherals present flag/enable pairs. Several pairs may feed one shared source number. The core contributes a software-trap request, an illegal-opcode request, a high-priority line gated by its own mask bit, and a level-sensitive external line. The core also provides its two mask bits and an instruction-boundary strobe.

For the chosen source the block outputs the source number and the address of its 16-bit vector slot. In bootstrap mode it also outputs the RAM entry point that the boot vector table holds for that source. At an instruction boundary it pulses a take strobe, together with an indication of which core mask bit the core must set. After each acceptance it waits out the core's fixed entry sequence before it can accept again. A programmable priority table orders the ordinary sources.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Pair p (0..17) raises source `tgt[p]` when its flag and enable are both 1. The map is 11,11,11,11,12,15,24,20,19,18,17,16,23,22,21,13,14,29. Pair 17 ignores its enable and raises source 29 whenever its flag is 1. Input changes reach the selection one clock later.
- R2: Source 11 is shared by pairs 0..3 and stays requested while any one of those pairs is active.
- R3: A pending trap request (source 27) is selected first, and then an illegal-opcode request (source 28). Neither is affected by either mask. Each stays pending from its request pulse until it is taken.
- R4: The high-priority request (source 26) is next. It is latched like R3 and gated only by `x_blk`. While it is pending and `x_blk` is 1, nothing at all is selected.
- R5: With no source 26..28 pending, `i_blk`=1 selects nothing. Otherwise the selected source is the pending source found at the lowest table index. When nothing is selected, `sel_id` is 0. A write with `ord_we` stores `ord_val` at index `ord_idx`.
- R6: Peripheral sources and the level line `irq_line` (source 25) are not cleared by being taken. They follow their inputs.
- R7: `vec_addr` = base + 2 × `sel_id`. The base is 0xFFC0 when the strap reads 0 and 0xBFC0 when it reads 1. The strap is sampled only while reset is active.
- R8: `take` = `boundary` AND `sel_valid` AND idle. On a take, `set_x` pulses for source 26 and `set_i` pulses for any other source.
- R9: After a take, `take` stays low for the following 13 cycles, so the earliest next take is 14 cycles later.
- R10: `boot_target` = 0x00A3 + 3 × `sel_id` in bootstrap mode and 0 otherwise.
- R11: Reset clears all pending state and loads the table with identity order (index k holds source k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_strap | input | 1 | Mode strap, sampled during reset |
| boundary | input | 1 | Core is at an instruction boundary |
| flag | input | 18 | Peripheral flag bits, one per pair |
| enab | input | 18 | Peripheral enable bits, one per pair |
| irq_line | input | 1 | Level-sensitive external request |
| nmi_req | input | 1 | High-priority request pulse |
| trap_req | input | 1 | Software trap request pulse |
| badop_req | input | 1 | Illegal-opcode request pulse |
| x_blk | input | 1 | Core mask bit for source 26 |
| i_blk | input | 1 | Core mask bit for ordinary sources |
| ord_we | input | 1 | Priority table write strobe |
| ord_idx | input | 5 | Priority table index |
| ord_val | input | 5 | Source number to store |
| sel_valid | output | 1 | A source is selected |
| sel_id | output | 5 | Selected source number |
| vec_addr | output | 16 | Address of the vector slot |
| boot_target | output | 16 | Boot table entry for the selected source |
| take | output | 1 | Acceptance strobe |
| set_x | output | 1 | Core must set its high mask bit |
| set_i | output | 1 | Core must set its ordinary mask bit |

## Verification
Directed sequences first cover each pair alone, with and without its enable, and several overlapping pairs on the shared serial source. These separate the AND-gating, the ungated pair and the OR of shared pairs. Simultaneous trap, illegal-opcode and high-priority pulses with both masks set separate the fixed ordering, the mask exemptions and the hold-off of all lower sources. A reprogrammed table with several peripherals pending separates table order from number order. Held flags with a continuous boundary show the level re-fire and the 14-cycle spacing. A bootstrap reset followed by a strap change shows the latched base. A long run of random flags, masks, pulses and table writes is then compared against a behavioural model on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC  = 32;
    localparam int IDW   = $clog2(NSRC);
    localparam int NPAIR = 18;

    typedef logic [IDW-1:0] src_id_t;

    localparam src_id_t ID_IRQ   = src_id_t'(25);
    localparam src_id_t ID_NMI   = src_id_t'(26);
    localparam src_id_t ID_TRAP  = src_id_t'(27);
    localparam src_id_t ID_BADOP = src_id_t'(28);

    // Source number raised by each peripheral flag/enable pair
    function automatic src_id_t pair_target(input int p);
        int t;
        case (p)
            0, 1, 2, 3: t = 11;
            4:  t = 12;
            5:  t = 15;
            6:  t = 24;
            7:  t = 20;
            8:  t = 19;
            9:  t = 18;
            10: t = 17;
            11: t = 16;
            12: t = 23;
            13: t = 22;
            14: t = 21;
            15: t = 13;
            16: t = 14;
            17: t = 29;
            default: t = 0;
        endcase
        return src_id_t'(t);
    endfunction

    // Pairs without an enable register are always armed
    function automatic logic pair_gated(input int p);
        return p != 17;
    endfunction
endpackage

// File: rtl/irqc_collect.sv
module irqc_collect
    import irqc_pkg::*;
(
    input  logic [NPAIR-1:0] flag,
    input  logic [NPAIR-1:0] enab,
    input  logic             irq_line,
    output logic [NSRC-1:0]  lvl
);
    logic [NPAIR-1:0] act;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam logic GATED = pair_gated(p);
        assign act[p] = flag[p] & (enab[p] | ~GATED);
    end

    // Shared sources: any active pair keeps the request asserted
    always_comb begin
        lvl = '0;
        lvl[ID_IRQ] = irq_line;
        for (int p = 0; p < NPAIR; p++) begin
            if (act[p]) lvl[pair_target(p)] = 1'b1;
        end
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ord_we,
    input  src_id_t         ord_idx,
    input  src_id_t         ord_val,
    input  logic [NSRC-1:0] pend,
    input  logic            x_blk,
    input  logic            i_blk,
    output logic            ok,
    output src_id_t         id
);
    src_id_t tab_d [NSRC];
    src_id_t tab_q [NSRC];

    always_comb begin
        tab_d = tab_q;
        if (ord_we) tab_d[ord_idx] = ord_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NSRC; k++) tab_q[k] <= src_id_t'(k);
        end else begin
            tab_q <= tab_d;
        end
    end

    always_comb begin
        ok = 1'b0;
        id = '0;
        if (pend[ID_TRAP]) begin
            ok = 1'b1;
            id = ID_TRAP;
        end else if (pend[ID_BADOP]) begin
            ok = 1'b1;
            id = ID_BADOP;
        end else if (pend[ID_NMI]) begin
            ok = ~x_blk;
            id = x_blk ? '0 : ID_NMI;
        end else if (!i_blk) begin
            // Walk downward so the lowest table index wins
            for (int k = NSRC - 1; k >= 0; k--) begin
                if (pend[tab_q[k]]) begin
                    ok = 1'b1;
                    id = tab_q[k];
                end
            end
        end
    end

    AST_NMI_HOLDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[ID_NMI] && x_blk && !pend[ID_TRAP] && !pend[ID_BADOP]) |-> !ok); // R4
    AST_IMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (i_blk && !pend[ID_NMI] && !pend[ID_TRAP] && !pend[ID_BADOP]) |-> !ok); // R5
    AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> pend[id]); // R5
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int          ACCEPT_CYC = 14,
    parameter logic [15:0] NORM_BASE  = 16'hFFC0,
    parameter logic [15:0] BOOT_BASE  = 16'hBFC0,
    parameter logic [15:0] RAM_TOP    = 16'h0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_strap,
    input  logic             boundary,
    input  logic [NPAIR-1:0] flag,
    input  logic [NPAIR-1:0] enab,
    input  logic             irq_line,
    input  logic             nmi_req,
    input  logic             trap_req,
    input  logic             badop_req,
    input  logic             x_blk,
    input  logic             i_blk,
    input  logic             ord_we,
    input  logic [IDW-1:0]   ord_idx,
    input  logic [IDW-1:0]   ord_val,
    output logic             sel_valid,
    output logic [IDW-1:0]   sel_id,
    output logic [15:0]      vec_addr,
    output logic [15:0]      boot_target,
    output logic             take,
    output logic             set_x,
    output logic             set_i
);
    localparam int CW = $clog2(ACCEPT_CYC);
    localparam logic [NSRC-1:0] STICKY = (NSRC'(1) << ID_NMI) |
                                         (NSRC'(1) << ID_TRAP) |
                                         (NSRC'(1) << ID_BADOP);
    localparam logic [15:0] BOOT_FIRST = RAM_TOP - 16'(3 * (NSRC - 1));

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic            boot;
        logic [CW-1:0]   busy;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] raise;
    logic            sel_ok;
    src_id_t         sel;
    logic            idle;
    logic            take_w;

    irqc_collect u_collect (
        .flag     (flag),
        .enab     (enab),
        .irq_line (irq_line),
        .lvl      (lvl)
    );

    irqc_pick u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ord_we  (ord_we),
        .ord_idx (ord_idx),
        .ord_val (ord_val),
        .pend    (st_q.pend),
        .x_blk   (x_blk),
        .i_blk   (i_blk),
        .ok      (sel_ok),
        .id      (sel)
    );

    always_comb begin
        raise = '0;
        raise[ID_NMI]   = nmi_req;
        raise[ID_TRAP]  = trap_req;
        raise[ID_BADOP] = badop_req;

        idle   = (st_q.busy == '0);
        take_w = boundary & sel_ok & idle;

        st_d      = st_q;
        st_d.pend = lvl & ~STICKY;
        for (int s = 0; s < NSRC; s++) begin
            if (STICKY[s]) begin
                st_d.pend[s] = raise[s] |
                               (st_q.pend[s] & ~(take_w && sel == src_id_t'(s)));
            end
        end
        if (take_w)     st_d.busy = CW'(ACCEPT_CYC - 1);
        else if (!idle) st_d.busy = st_q.busy - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.boot <= boot_strap;
            st_q.busy <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_valid   = sel_ok;
    assign sel_id      = sel;
    assign vec_addr    = (st_q.boot ? BOOT_BASE : NORM_BASE) + 16'({sel, 1'b0});
    assign boot_target = st_q.boot ? BOOT_FIRST + 16'(sel) * 16'd3 : 16'h0000;
    assign take        = take_w;
    assign set_x       = take_w & (sel == ID_NMI);
    assign set_i       = take_w & (sel != ID_NMI);

    AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend[ID_TRAP] |-> (sel_valid && sel_id == ID_TRAP)); // R3
    AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sel_id == ID_TRAP && !trap_req) |=> !st_q.pend[ID_TRAP]); // R3
    AST_LEVEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sel_id == ID_IRQ && irq_line) |=> st_q.pend[ID_IRQ]); // R6
    AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(st_q.boot)); // R7
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (boundary && sel_valid)); // R8
    AST_ONE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($countones({set_x, set_i}) == 1)); // R8
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take); // R9
endmodule

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_strap = 1'b0;
    logic        boundary = 1'b0;
    logic [17:0] flag = '0;
    logic [17:0] enab = '0;
    logic        irq_line = 1'b0;
    logic        nmi_req = 1'b0;
    logic        trap_req = 1'b0;
    logic        badop_req = 1'b0;
    logic        x_blk = 1'b0;
    logic        i_blk = 1'b0;
    logic        ord_we = 1'b0;
    logic [4:0]  ord_idx = '0;
    logic [4:0]  ord_val = '0;
    logic        sel_valid;
    logic [4:0]  sel_id;
    logic [15:0] vec_addr;
    logic [15:0] boot_target;
    logic        take;
    logic        set_x;
    logic        set_i;

    always #4 clk = ~clk;

    vec_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .boundary(boundary),
        .flag(flag), .enab(enab), .irq_line(irq_line), .nmi_req(nmi_req),
        .trap_req(trap_req), .badop_req(badop_req), .x_blk(x_blk), .i_blk(i_blk),
        .ord_we(ord_we), .ord_idx(ord_idx), .ord_val(ord_val),
        .sel_valid(sel_valid), .sel_id(sel_id), .vec_addr(vec_addr),
        .boot_target(boot_target), .take(take), .set_x(set_x), .set_i(set_i)
    );

    // Behavioural reference state
    int    tgt [18] = '{11,11,11,11,12,15,24,20,19,18,17,16,23,22,21,13,14,29};
    bit    m_pend [32];
    int    m_ord [32];
    bit    m_boot;
    int    m_busy;
    int    n_chk = 0;
    int    n_bad = 0;
    string phase = "R11";

    task automatic compare(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic do_reset(bit strap);
        rst_n = 1'b0;
        boot_strap = strap;
        boundary = 0; flag = '0; enab = '0; irq_line = 0;
        nmi_req = 0; trap_req = 0; badop_req = 0; x_blk = 0; i_blk = 0; ord_we = 0;
        repeat (3) @(posedge clk);
        for (int s = 0; s < 32; s++) begin
            m_pend[s] = 0;
            m_ord[s] = s;
        end
        m_boot = strap;
        m_busy = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Compare one cycle, then advance model and design by one clock
    task automatic step();
        bit eok, etake;
        int eid, base;
        bit nxt [32];
        #1;
        eok = 0; eid = 0;
        if (m_pend[27]) begin eok = 1; eid = 27; end
        else if (m_pend[28]) begin eok = 1; eid = 28; end
        else if (m_pend[26]) begin
            if (!x_blk) begin eok = 1; eid = 26; end
        end else if (!i_blk) begin
            for (int k = 0; k < 32 && !eok; k++) begin
                if (m_pend[m_ord[k]]) begin eok = 1; eid = m_ord[k]; end
            end
        end
        etake = boundary && eok && (m_busy == 0);
        base = m_boot ? 'hBFC0 : 'hFFC0;
        compare("sel_valid", sel_valid, eok);
        compare("sel_id", sel_id, eid);
        compare("vec_addr", vec_addr, (base + 2 * eid) & 'hFFFF);
        compare("boot_target", boot_target, m_boot ? ('hA3 + 3 * eid) : 0);
        compare("take", take, etake);
        compare("set_x", set_x, etake && eid == 26);
        compare("set_i", set_i, etake && eid != 26);

        for (int s = 0; s < 32; s++) nxt[s] = 0;
        for (int p = 0; p < 18; p++) begin
            if (flag[p] && (p == 17 || enab[p])) nxt[tgt[p]] = 1;
        end
        if (irq_line) nxt[25] = 1;
        nxt[26] = nmi_req   || (m_pend[26] && !(etake && eid == 26));
        nxt[27] = trap_req  || (m_pend[27] && !(etake && eid == 27));
        nxt[28] = badop_req || (m_pend[28] && !(etake && eid == 28));
        @(posedge clk);
        for (int s = 0; s < 32; s++) m_pend[s] = nxt[s];
        if (etake) m_busy = 13;
        else if (m_busy > 0) m_busy = m_busy - 1;
        if (ord_we) m_ord[ord_idx] = ord_val;
        @(negedge clk);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R11: reset state
        do_reset(1'b0);
        phase = "R11";
        steps(4);

        // R1: gating by enable and the ungated pair
        phase = "R1";
        flag[5] = 1; steps(3);
        enab[5] = 1; steps(3);
        flag[5] = 0; enab[5] = 0; flag[17] = 1; steps(3);
        flag[17] = 0; enab[9] = 1; steps(2);
        flag[9] = 1; steps(3);
        flag[9] = 0; enab[9] = 0; steps(2);

        // R2: shared serial source
        phase = "R2";
        flag[1] = 1; enab[1] = 1; flag[2] = 1; enab[2] = 1; flag[3] = 1; steps(3);
        flag[1] = 0; steps(3);
        enab[2] = 0; steps(3);
        enab[3] = 1; steps(2);
        flag = '0; enab = '0; steps(3);

        // R4: held-off high-priority request blocks everything
        phase = "R4";
        flag[4] = 1; enab[4] = 1; x_blk = 1; nmi_req = 1; step();
        nmi_req = 0; steps(5);
        x_blk = 0; steps(3);
        flag[4] = 0; enab[4] = 0; steps(2);

        // R3: fixed top priorities, unmaskable, cleared when taken
        phase = "R3";
        do_reset(1'b0);
        x_blk = 1; i_blk = 1; irq_line = 1;
        trap_req = 1; badop_req = 1; nmi_req = 1; step();
        trap_req = 0; badop_req = 0; nmi_req = 0; steps(3);
        boundary = 1; steps(35);
        x_blk = 0; steps(16);

        // R6: level sources fire again while held
        phase = "R6";
        i_blk = 0; steps(30);
        irq_line = 0; flag[6] = 1; enab[6] = 1; steps(32);
        flag[6] = 0; steps(4);

        // R5: mask and programmable order
        phase = "R5";
        boundary = 0; i_blk = 1;
        flag[14] = 1; enab[14] = 1; flag[15] = 1; enab[15] = 1; flag[5] = 1; enab[5] = 1;
        steps(3);
        i_blk = 0; steps(2);
        ord_we = 1; ord_idx = 0; ord_val = 21; step();
        ord_idx = 1; ord_val = 13; step();
        ord_we = 0; steps(3);
        flag[14] = 0; steps(3);
        flag[15] = 0; steps(3);
        flag = '0; enab = '0; steps(2);

        // R8 / R9: boundary pattern against the acceptance spacing
        phase = "R8";
        irq_line = 1; flag[12] = 1; enab[12] = 1;
        for (int k = 0; k < 40; k++) begin
            boundary = (k % 3 == 0); step();
        end
        phase = "R9";
        boundary = 1; steps(45);
        boundary = 0; irq_line = 0; flag = '0; enab = '0; steps(2);

        // R7 / R10: bootstrap base latched at reset
        do_reset(1'b1);
        phase = "R7";
        irq_line = 1; steps(3);
        boot_strap = 0; steps(5);
        phase = "R10";
        flag[0] = 1; enab[0] = 1; irq_line = 0; steps(3);
        trap_req = 1; step();
        trap_req = 0; boundary = 1; steps(20);
        boundary = 0; flag = '0; enab = '0; steps(2);

        // Random mix in normal mode
        do_reset(1'b0);
        phase = "R5";
        for (int n = 0; n < 2500; n++) begin
            flag      = 18'($urandom);
            enab      = 18'($urandom);
            irq_line  = ($urandom % 4) == 0;
            nmi_req   = ($urandom % 32) == 0;
            trap_req  = ($urandom % 40) == 0;
            badop_req = ($urandom % 40) == 0;
            x_blk     = ($urandom % 3) == 0;
            i_blk     = ($urandom % 3) == 0;
            boundary  = ($urandom % 2) == 0;
            ord_we    = ($urandom % 10) == 0;
            ord_idx   = 5'($urandom);
            ord_val   = 5'($urandom);
            step();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule